// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven command engine for a serial flash device. Software places a command byte and a 24-bit flash address in one 32-bit register, and optional payload bytes in a second 32-bit register. It then writes a control word that holds a transmit byte count, a receive byte count, a clock-rate select and a start bit. The engine frames the transfer with chip select, clocks out the transmit bytes on MOSI in SPI mode 0, and then clocks in the receive bytes from MISO. The received bytes are packed into the data register.

Software polls a busy flag in the control register until it clears. It then reads the result from the data register. While the flag is set, every register write is dropped, so a command in flight cannot be disturbed.

Top module: `spi_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, chip select is high, SCK and MOSI are low, busy is clear, and all three registers read as zero.
- R2: The register word index is address bits 3:2. Index 0 is control, index 1 is command/address and index 2 is data; index 3 reads zero.
- R3: In the control word, bits 3:0 are the transmit count, bits 7:4 the receive count and bits 18:17 a stored size field. Bits 25:24 are the clock select and bit 8 is start, which always reads 0. Bit 16 is the read-only busy flag.
- R4: A control write with start set, made while idle and with at least one nonzero count, sets busy and drives chip select low from the next cycle. Both are held for 2H·(8N+1) cycles, where N is the total number of bytes and H = 2^select. Then chip select returns high and busy clears together.
- R5: SCK idles low. Each bit spends H cycles low and then H cycles high. The last bit is followed by one full SCK period (2H cycles) with SCK low and chip select still asserted.
- R6: The transmit bytes go out in this order: command byte (bits 7:0), then address bits 31:24, 23:16 and 15:8. Counts 5 to 8 continue with data-register bytes, lowest byte first. Each byte is sent MSB first. MOSI holds its bit for the whole SCK period and is 0 during receive bits and outside a transfer.
- R7: MISO is sampled on each rising SCK edge, MSB first. Receive byte j (j from 0) lands in data bits 8j+7:8j, and the data bytes above the receive count keep their earlier value.
- R8: A transmit count of 9 to 15 acts as 8, and a receive count of 5 to 15 acts as 4. A start with both counts zero is ignored: busy stays clear and chip select stays high.
- R9: While busy is set, writes to the control, command/address and data registers have no effect. A start bit written during a transfer neither restarts nor lengthens it.
- R10: Clock select values 0, 1, 2 and 3 give an SCK period of 2, 4, 8 and 16 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register (bits 3:2 select the word) |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read data for reg_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with its default parameters: a 4-bit address, up to eight transmit and four receive bytes, and a 2-bit clock select. With these values it can reach every divider ratio, the longest 12-byte frame, and both count clamps. A behavioural model predicts chip select, SCK, MOSI and busy on every clock for each transfer. The model also plays the flash side on MISO. Transfers cover command-only, status-style, signature-style, full read, page-program-style and maximum-length cases, plus register pokes made in the middle of a transfer.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the SPI command engine.
// Assumes 32-bit registers and a word index taken from address bits 3:2.
package spi_cmd_pkg;
    localparam int REG_W     = 32;
    localparam int WORD_CTL  = 0;
    localparam int WORD_OPA  = 1;
    localparam int WORD_DAT  = 2;
    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_TAIL  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [1:0] size;
        logic [3:0] rx_cnt;
        logic [3:0] tx_cnt;
    } ctl_t;
endpackage

// File: rtl/spi_cmd_clkdiv.sv
// Half-period tick generator for SCK. While run is high it pulses tick once
// every 2^sel cycles, and its count restarts from zero whenever run is low.
// Assumes sel stays stable while run is high.
module spi_cmd_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Limit is 2^sel - 1, built as sel low-order ones.
    always_comb limit = ALL_ONES >> (CNT_W - int'(sel));

    assign tick = run && (cnt_q == limit);

    // Count system clocks inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_cmd_regs.sv
// Register file: control, command/address and data words.
// Assumes rx_we is asserted only while busy, so it never meets a bus write.
// Raises start for one cycle when an idle control write requests a transfer.
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              busy,
    output logic              start,
    output ctl_t              ctl_q,
    output logic [REG_W-1:0]  opa_q,
    output logic [REG_W-1:0]  dat_q,
    input  logic              rx_we,
    input  logic [1:0]        rx_idx,
    input  logic [7:0]        rx_byte
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              bus_wr;

    assign word   = reg_addr[ADDR_W-1:2];
    assign bus_wr = wr_en && !busy;
    assign start  = bus_wr && (word == WORD_W'(WORD_CTL)) && wr_data[START_BIT]
                    && (wr_data[7:0] != 8'd0);

    // Hold register contents; bus writes while idle, receive bytes while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            opa_q <= '0;
            dat_q <= '0;
        end else if (bus_wr) begin
            case (word)
                WORD_W'(WORD_CTL): begin
                    ctl_q.tx_cnt  <= wr_data[3:0];
                    ctl_q.rx_cnt  <= wr_data[7:4];
                    ctl_q.size    <= wr_data[18:17];
                    ctl_q.clk_sel <= wr_data[25:24];
                end
                WORD_W'(WORD_OPA): opa_q <= wr_data;
                WORD_W'(WORD_DAT): dat_q <= wr_data;
                default: ;
            endcase
        end else if (rx_we) begin
            dat_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
        end
    end

    // Read mux; start always reads zero, busy is live.
    always_comb begin
        rd_data = '0;
        case (word)
            WORD_W'(WORD_CTL): begin
                rd_data[3:0]     = ctl_q.tx_cnt;
                rd_data[7:4]     = ctl_q.rx_cnt;
                rd_data[BUSY_BIT] = busy;
                rd_data[18:17]   = ctl_q.size;
                rd_data[25:24]   = ctl_q.clk_sel;
            end
            WORD_W'(WORD_OPA): rd_data = opa_q;
            WORD_W'(WORD_DAT): rd_data = dat_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_cmd_seq.sv
// Byte sequencer and mode-0 shifter. It sends the clamped transmit bytes and
// then collects the receive bytes, finishing with one idle SCK period before
// chip select is released. Assumes MAX_TX <= 8, MAX_RX <= 4, and that the
// counts and words stay stable while busy.
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int MAX_TX = 8,
    parameter int MAX_RX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       tx_cnt,
    input  logic [3:0]       rx_cnt,
    input  logic [REG_W-1:0] opa,
    input  logic [REG_W-1:0] dat,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    output logic             rx_we,
    output logic [1:0]       rx_idx,
    output logic [7:0]       rx_byte
);
    localparam int BIT_W = $clog2(8 * (MAX_TX + MAX_RX) + 1);
    localparam int IDX_W = BIT_W - 3;

    seq_state_t       state_q;
    logic             phase_q;
    logic             tail_half_q;
    logic [BIT_W-1:0] bit_q;
    logic [6:0]       rx_sr_q;

    logic [3:0]       eff_tx, eff_rx;
    logic [BIT_W-1:0] total_bits;
    logic [IDX_W-1:0] byte_idx;
    logic [2:0]       bit_in_byte;
    logic             in_tx, last_bit;
    logic [7:0]       tx_byte;
    logic [1:0]       dsel;

    // Clamp the programmed counts to the supported maxima.
    always_comb begin
        eff_tx = (tx_cnt > 4'(MAX_TX)) ? 4'(MAX_TX) : tx_cnt;
        eff_rx = (rx_cnt > 4'(MAX_RX)) ? 4'(MAX_RX) : rx_cnt;
    end

    assign total_bits  = BIT_W'((32'(eff_tx) + 32'(eff_rx)) * 8);
    assign byte_idx    = bit_q[BIT_W-1:3];
    assign bit_in_byte = bit_q[2:0];
    assign in_tx       = 4'(byte_idx) < eff_tx;
    assign last_bit    = (bit_q == total_bits - 1'b1);
    assign dsel        = 2'(4'(byte_idx) - 4'd4);

    // Pick the outgoing byte: command, address high to low, then data low first.
    always_comb begin
        case (4'(byte_idx))
            4'd0:    tx_byte = opa[7:0];
            4'd1:    tx_byte = opa[31:24];
            4'd2:    tx_byte = opa[23:16];
            4'd3:    tx_byte = opa[15:8];
            default: tx_byte = dat[{dsel, 3'b000} +: 8];
        endcase
    end

    assign busy    = (state_q != SEQ_IDLE);
    assign sck     = phase_q;
    assign mosi    = (state_q == SEQ_SHIFT) && in_tx && tx_byte[3'd7 - bit_in_byte];
    assign rx_we   = (state_q == SEQ_SHIFT) && tick && !phase_q && !in_tx
                     && (bit_in_byte == 3'd7);
    assign rx_idx  = 2'(4'(byte_idx) - eff_tx);
    assign rx_byte = {rx_sr_q, miso};

    // Advance through bit phases, the trailing period, and frame control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            phase_q     <= 1'b0;
            tail_half_q <= 1'b0;
            bit_q       <= '0;
            rx_sr_q     <= '0;
            cs_n        <= 1'b1;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_SHIFT;
                    bit_q   <= '0;
                    phase_q <= 1'b0;
                    cs_n    <= 1'b0;
                end
                SEQ_SHIFT: if (tick) begin
                    if (!phase_q) begin
                        phase_q <= 1'b1;
                        if (!in_tx) rx_sr_q <= {rx_sr_q[5:0], miso};
                    end else begin
                        phase_q <= 1'b0;
                        if (last_bit) begin
                            state_q     <= SEQ_TAIL;
                            tail_half_q <= 1'b0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                SEQ_TAIL: if (tick) begin
                    if (!tail_half_q) tail_half_q <= 1'b1;
                    else begin
                        state_q <= SEQ_IDLE;
                        cs_n    <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the SPI command engine: register file, SCK divider and sequencer.
// Assumes a single-cycle write strobe and combinational reads.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int MAX_TX = 8,
    parameter int MAX_RX = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic             busy, start, tick, rx_we;
    logic [1:0]       rx_idx;
    logic [7:0]       rx_byte;
    ctl_t             ctl_q;
    logic [REG_W-1:0] opa_q, dat_q;

    spi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .start(start),
        .ctl_q(ctl_q), .opa_q(opa_q), .dat_q(dat_q),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
    );

    spi_cmd_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .sel(SEL_W'(ctl_q.clk_sel)), .tick(tick)
    );

    spi_cmd_seq #(.MAX_TX(MAX_TX), .MAX_RX(MAX_RX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_cnt(ctl_q.tx_cnt), .rx_cnt(ctl_q.rx_cnt),
        .opa(opa_q), .dat(dat_q), .tick(tick), .miso(spi_miso),
        .busy(busy), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_cmd_checker.sv
// Protocol checks for the SPI command engine, bound into the top module.
// Assumes the register word index is address bits 3:2.
module spi_cmd_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       wr_data,
    input logic              busy,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic              spi_cs_n,
    input logic [31:0]       opa
);
    logic ctl_sel;
    assign ctl_sel = (reg_addr[ADDR_W-1:2] == '0);

    // R1: reset leaves the serial side idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !spi_sck && !busy));

    // R4: chip select is low exactly while busy.
    assert_cs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n == !busy);

    // R4: an idle start with nonzero counts raises busy.
    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && ctl_sel && wr_data[8] && wr_data[7:0] != 8'd0) |=> busy);

    // R5: SCK pulses only inside a frame.
    assert_sck_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    // R6: MOSI is quiet outside a frame.
    assert_mosi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    // R8: a start with zero counts does not raise busy.
    assert_zero_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && ctl_sel && wr_data[8] && wr_data[7:0] == 8'd0) |=> !busy);

    // R9: a write during a transfer leaves the command word alone.
    assert_opa_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(opa));
endmodule

bind spi_cmd_engine spi_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .opa(opa_q)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural frame model predicts the serial pins every clock and
// plays the flash on MISO; register contents are checked after each frame.
module spi_cmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        miso = 1'b0;
    logic        sck, mosi, cs_n;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
        reg_addr = '0;
    endtask

    // One complete frame against the model; poke adds writes mid-frame.
    task automatic xfer(input string req, input logic [31:0] op, input logic [31:0] dat,
                        input logic [3:0] txf, input logic [3:0] rxf, input logic [1:0] sel,
                        input logic [31:0] rx_word, input bit poke);
        int ntx, nrx, h, nb, total;
        logic [7:0]  txb [8];
        logic [31:0] exp_dat, ctl_word, got;
        ntx = (txf > 8) ? 8 : int'(txf);
        nrx = (rxf > 4) ? 4 : int'(rxf);
        h = 1 << sel;
        nb = 8 * (ntx + nrx);
        total = 2 * h * (nb + 1);
        txb[0] = op[7:0]; txb[1] = op[31:24]; txb[2] = op[23:16]; txb[3] = op[15:8];
        for (int k = 0; k < 4; k++) txb[4 + k] = dat[8*k +: 8];
        exp_dat = dat;
        for (int j = 0; j < nrx; j++) exp_dat[8*j +: 8] = rx_word[8*j +: 8];
        ctl_word = (32'(sel) << 24) | (32'd2 << 17) | (32'd1 << 8) | (32'(rxf) << 4) | 32'(txf);
        wr(4'h4, op);
        wr(4'h8, dat);
        @(negedge clk);
        reg_addr = 4'h0; wr_data = ctl_word; wr_en = 1'b1;
        for (int c = 0; c < total + 2; c++) begin
            logic [3:0] exp_pins;
            @(negedge clk);
            wr_en = 1'b0; reg_addr = 4'h0;
            #1;
            if (c < total) begin
                int i;
                logic e_sck, e_mosi;
                i = c / (2 * h);
                e_sck  = (i < nb) && ((c % (2 * h)) >= h);
                e_mosi = (i < 8 * ntx) ? txb[i / 8][7 - (i % 8)] : 1'b0;
                exp_pins = {1'b1, 1'b0, e_sck, e_mosi};
                miso = (i >= 8 * ntx && i < nb) ?
                       rx_word[8 * (i / 8 - ntx) + 7 - (i % 8)] : 1'b0;
            end else begin
                exp_pins = {1'b0, 1'b1, 1'b0, 1'b0};
                miso = 1'b0;
            end
            // R4 R5 R6 R10: {busy, cs_n, sck, mosi} every cycle.
            chk(req, $sformatf("pins c=%0d", c),
                {28'd0, rd_data[16], cs_n, sck, mosi}, {28'd0, exp_pins});
            if (poke && c == 1) begin reg_addr = 4'h4; wr_data = 32'hFFFF_FFFF; wr_en = 1'b1; end
            if (poke && c == 2) begin reg_addr = 4'h8; wr_data = 32'h1234_5678; wr_en = 1'b1; end
            if (poke && c == 3) begin reg_addr = 4'h0; wr_data = 32'h0000_0111; wr_en = 1'b1; end
        end
        rd(4'h8, got);
        chk("R7", "data after frame", got, exp_dat);
        rd(4'h4, got);
        chk(poke ? "R9" : "R2", "cmd word after frame", got, op);
        rd(4'h0, got);
        chk(poke ? "R9" : "R3", "ctl after frame", got, ctl_word & 32'hFFFF_FEFF);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1", "pins", {29'd0, cs_n, sck, mosi}, {29'd0, 3'b100});
        rd(4'h0, v); chk("R1", "ctl", v, 32'h0);
        rd(4'h4, v); chk("R1", "cmd", v, 32'h0);
        rd(4'h8, v); chk("R1", "data", v, 32'h0);
        // R2 R3: field layout, start reads 0, index 3 reads 0.
        wr(4'h0, 32'hFFFF_FEFF);
        rd(4'h0, v); chk("R3", "ctl fields", v, 32'h0306_00FF);
        chk("R3", "no start", {31'd0, cs_n}, 32'd1);
        wr(4'h4, 32'hA1B2_C3D4); rd(4'h4, v); chk("R2", "cmd rw", v, 32'hA1B2_C3D4);
        wr(4'h8, 32'h0BAD_F00D); rd(4'h8, v); chk("R2", "data rw", v, 32'h0BAD_F00D);
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); chk("R2", "word3", v, 32'h0);
        // R4 R5 R6 R10: command-only frames at several rates.
        xfer("R6", 32'h0000_0006, 32'h0, 4'd1, 4'd0, 2'd0, 32'h0, 1'b0);
        xfer("R10", 32'h0000_0005, 32'h0, 4'd1, 4'd1, 2'd1, 32'h0000_005A, 1'b0);
        // R7: one byte received, upper bytes preserved.
        xfer("R7", 32'h0000_00AB, 32'hFFFF_FFFF, 4'd4, 4'd1, 2'd2, 32'h0000_0014, 1'b0);
        xfer("R7", 32'h1234_5603, 32'h0, 4'd4, 4'd4, 2'd0, 32'h4433_2211, 1'b0);
        // R6 R9 R10: data-register bytes, slowest rate, writes during frame.
        xfer("R9", 32'h0001_0002, 32'hDDCC_BBAA, 4'd6, 4'd0, 2'd3, 32'h0, 1'b1);
        xfer("R6", 32'hA5C3_E781, 32'h0F1E_2D3C, 4'd8, 4'd4, 2'd0, 32'h89AB_CDEF, 1'b0);
        // R8: clamped counts, then a zero-count start.
        xfer("R8", 32'h5566_7788, 32'hCAFE_F00D, 4'd12, 4'd9, 2'd1, 32'h7E3C_1896, 1'b0);
        wr(4'h0, 32'h0000_0100);
        for (int k = 0; k < 4; k++) begin
            rd(4'h0, v);
            chk("R8", "zero start idle", {30'd0, v[16], cs_n}, 32'd1);
            @(negedge clk);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule